// File: doc/BRIEF.md
# Keyed Configuration Window Decoder

This block sits on the host side of a 16-bit I/O port bus. It turns accesses into PCI configuration cycles with the keyed-window method. Three byte registers control it:

- a key/function register at 0xCF8;
- a bus-number register at 0xCFA;
- a mechanism-select register at 0xCFB.

While the window is open, a port in the 0xC000–0xCFFF page names a device in port bits 11:8 and a configuration register in port bits 7:0. Each such byte becomes one request on a downstream valid/ready interface. The request carries the latched bus and function numbers.

The upstream side accepts byte, word and dword accesses as a one-cycle request pulse taken while the block is idle. A wider access is cut into consecutive byte steps at port, port+1, and so on. The steps run strictly in order, so a control-register write in one step affects the decoding of the next. One acknowledge pulse closes the access.

A parameter mask lists the devices that are present. A strap input selects device-zero mode: in that mode ports 0xC000–0xC0FF reach device 0 whatever the key. The strap is held stable from reset on.

Top module: `cfg2_decoder`

## Requirements
- R1: After reset, bytes read from 0xCF8, 0xCFA and 0xCFB are all 0x00, and the window is closed.
- R2: A byte written to 0xCF8 stores a key from bits 7:4 and a function number from bits 3:1. Reading 0xCF8 returns the key in bits 7:4, the function in bits 3:1 and 0 in bit 0. A nonzero key opens the window and a zero key closes it.
- R3: A byte written to 0xCFA stores the bus number, reads back unchanged, and opens the window even with a zero key.
- R4: 0xCFB reads back the last byte written to it. A write that changes its bit 0 from 0 to 1 closes the window. A write that changes bit 0 from 1 to 0 reopens the window if the key is nonzero or if 0xCFA was written after the last 0xCF8 write.
- R5: A byte at a port in the open window, other than the three control ports, is sent downstream with device = port[11:8], register = port[7:0], and the stored bus and function numbers. The write flag and the data byte go with it.
- R6: With the strap set, ports 0xC000–0xC0FF reach device 0 whatever the key, and ports 0xC100–0xCFFF follow the key. With the strap clear, the whole 0xC000–0xCFFF page follows the key.
- R7: A byte for an absent device, or for a port outside the control ports and the active window, reads 0xFF. A write to such a byte is dropped, and no downstream request is issued for it.
- R8: io_size_i 0 selects one byte, 1 selects two and 2 or 3 selects four. The bytes are handled at ascending ports (with 16-bit wrap), one after another. Byte i occupies bits 8i+7:8i of the data, and lanes not covered read 0xFF.
- R9: At most one downstream request is outstanding. Its fields hold steady until cfg_ready_i is seen. The upstream acknowledge comes only after every byte step has finished.
- R10: An access whose first port is neither a control port nor in the active window is acknowledged with io_unclaimed_o high and read data 0xFFFFFFFF. It has no effect on any state and issues no downstream request.
- R11: io_ack_o is a single-cycle pulse. With cfg_ready_i held high, an access of n bytes is acknowledged n cycles after the edge that captures it, and an unclaimed access 0 cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev0_en_i | input | 1 | Device-zero mode strap, held stable |
| io_req_i | input | 1 | Access request pulse, taken when idle |
| io_we_i | input | 1 | 1 = write, 0 = read |
| io_size_i | input | 2 | 0 byte, 1 word, 2/3 dword |
| io_addr_i | input | 16 | I/O port of the first byte |
| io_wdata_i | input | 32 | Write data, byte i in bits 8i+7:8i |
| io_ack_o | output | 1 | Access finished, one cycle |
| io_unclaimed_o | output | 1 | Access was not claimed (valid with ack) |
| io_rdata_o | output | 32 | Read data (valid with ack) |
| cfg_valid_o | output | 1 | Downstream request valid |
| cfg_ready_i | input | 1 | Downstream request taken |
| cfg_we_o | output | 1 | Downstream write flag |
| cfg_bus_o | output | 8 | Bus number |
| cfg_dev_o | output | 4 | Device number |
| cfg_func_o | output | 3 | Function number |
| cfg_reg_o | output | 8 | Configuration register index |
| cfg_wdata_o | output | 8 | Write data byte |
| cfg_rdata_i | input | 8 | Read data byte, same cycle as ready |

## Verification
The request is driven on a falling edge and captured on the next rising edge. A claimed access then takes one cycle per byte plus one cycle for every cycle in which a downstream request waits for ready. The acknowledge shows on the falling edge that follows the last byte step, one cycle after capture for an unclaimed access. The bench reads the data, the unclaimed flag and the logged downstream requests at that falling edge. It checks the exact count of cycles whenever ready is held high, and waits one more cycle before the next request so that the block is idle again.

// File: rtl/cfg2_pkg.sv
package cfg2_pkg;
  localparam int PORT_W = 16;
  localparam int DATA_W = 32;
  localparam int NBYTE  = DATA_W / 8;
  localparam int IDX_W  = $clog2(NBYTE);
  localparam int NDEV   = 16;

  localparam logic [PORT_W-1:0] KEY_PORT  = 16'hCF8;
  localparam logic [PORT_W-1:0] BUS_PORT  = 16'hCFA;
  localparam logic [PORT_W-1:0] MECH_PORT = 16'hCFB;
  localparam logic [3:0]        WIN_PAGE  = 4'hC;

  typedef enum logic [2:0] {CLS_MISS, CLS_KEY, CLS_BUS, CLS_MECH, CLS_WIN} port_cls_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} seq_st_e;
endpackage

// File: rtl/cfg2_port_class.sv
module cfg2_port_class
  import cfg2_pkg::*;
(
  input  logic [PORT_W-1:0] port_i,
  input  logic              win_open_i,
  input  logic              dev0_en_i,
  output port_cls_e         cls_o
);
  always_comb begin
    cls_o = CLS_MISS;
    if (port_i == KEY_PORT)       cls_o = CLS_KEY;
    else if (port_i == BUS_PORT)  cls_o = CLS_BUS;
    else if (port_i == MECH_PORT) cls_o = CLS_MECH;
    else if (port_i[15:12] == WIN_PAGE) begin
      // device-0 page stays reachable in strap mode, rest follows the key
      if (port_i[11:8] == 4'h0) cls_o = (win_open_i || dev0_en_i) ? CLS_WIN : CLS_MISS;
      else                      cls_o = win_open_i ? CLS_WIN : CLS_MISS;
    end
  end
endmodule

// File: rtl/cfg2_ctrl_regs.sv
module cfg2_ctrl_regs
  import cfg2_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  port_cls_e  cls_i,
  input  logic [7:0] wdata_i,
  output logic [2:0] func_o,
  output logic [7:0] bus_o,
  output logic       open_o,
  output logic [7:0] rdata_o
);
  logic [3:0] key_q;
  logic [7:0] mech_q;
  logic       forced_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q    <= '0;
      func_o   <= '0;
      bus_o    <= '0;
      mech_q   <= '0;
      forced_q <= 1'b0;
      open_o   <= 1'b0;
    end else if (wr_i) begin
      unique case (cls_i)
        CLS_KEY: begin
          key_q    <= wdata_i[7:4];
          func_o   <= wdata_i[3:1];
          forced_q <= 1'b0;
          open_o   <= |wdata_i[7:4];
        end
        CLS_BUS: begin
          bus_o    <= wdata_i;
          forced_q <= 1'b1;
          open_o   <= 1'b1;
        end
        CLS_MECH: begin
          mech_q <= wdata_i;
          if (!mech_q[0] && wdata_i[0])      open_o <= 1'b0;
          else if (mech_q[0] && !wdata_i[0]) open_o <= (key_q != '0) || forced_q;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (cls_i)
      CLS_KEY:  rdata_o = {key_q, func_o, 1'b0};
      CLS_BUS:  rdata_o = bus_o;
      CLS_MECH: rdata_o = mech_q;
      default:  rdata_o = 8'hFF;
    endcase
  end
endmodule

// File: rtl/cfg2_decoder.sv
module cfg2_decoder
  import cfg2_pkg::*;
#(
  parameter logic [NDEV-1:0] DEV_PRESENT = 16'hFFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dev0_en_i,
  input  logic              io_req_i,
  input  logic              io_we_i,
  input  logic [1:0]        io_size_i,
  input  logic [PORT_W-1:0] io_addr_i,
  input  logic [DATA_W-1:0] io_wdata_i,
  output logic              io_ack_o,
  output logic              io_unclaimed_o,
  output logic [DATA_W-1:0] io_rdata_o,
  output logic              cfg_valid_o,
  input  logic              cfg_ready_i,
  output logic              cfg_we_o,
  output logic [7:0]        cfg_bus_o,
  output logic [3:0]        cfg_dev_o,
  output logic [2:0]        cfg_func_o,
  output logic [7:0]        cfg_reg_o,
  output logic [7:0]        cfg_wdata_o,
  input  logic [7:0]        cfg_rdata_i
);
  seq_st_e           st_q;
  logic [PORT_W-1:0] base_q, cur_port;
  logic              we_q, unclaimed_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [IDX_W-1:0]  idx_q, last_q, last_d;
  port_cls_e         start_cls, cur_cls;
  logic              win_open, tgt, ctrl_hit, byte_done;
  logic [7:0]        reg_rd, byte_rd;

  assign cur_port = base_q + PORT_W'(idx_q);

  cfg2_port_class u_start_cls (
    .port_i(io_addr_i), .win_open_i(win_open), .dev0_en_i(dev0_en_i), .cls_o(start_cls)
  );
  cfg2_port_class u_cur_cls (
    .port_i(cur_port), .win_open_i(win_open), .dev0_en_i(dev0_en_i), .cls_o(cur_cls)
  );

  assign tgt       = (st_q == ST_RUN) && (cur_cls == CLS_WIN) && DEV_PRESENT[cur_port[11:8]];
  assign ctrl_hit  = (cur_cls == CLS_KEY) || (cur_cls == CLS_BUS) || (cur_cls == CLS_MECH);
  assign byte_done = (st_q == ST_RUN) && (!tgt || cfg_ready_i);
  assign byte_rd   = tgt ? cfg_rdata_i : (ctrl_hit ? reg_rd : 8'hFF);

  cfg2_ctrl_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (byte_done && we_q && ctrl_hit),
    .cls_i   (cur_cls),
    .wdata_i (wdata_q[8*idx_q +: 8]),
    .func_o  (cfg_func_o),
    .bus_o   (cfg_bus_o),
    .open_o  (win_open),
    .rdata_o (reg_rd)
  );

  always_comb begin
    unique case (io_size_i)
      2'd0:    last_d = IDX_W'(0);
      2'd1:    last_d = IDX_W'(1);
      default: last_d = IDX_W'(NBYTE - 1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      base_q      <= '0;
      we_q        <= 1'b0;
      wdata_q     <= '0;
      rdata_q     <= '1;
      idx_q       <= '0;
      last_q      <= '0;
      unclaimed_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (io_req_i) begin
          base_q      <= io_addr_i;
          we_q        <= io_we_i;
          wdata_q     <= io_wdata_i;
          last_q      <= last_d;
          idx_q       <= '0;
          rdata_q     <= '1;
          unclaimed_q <= (start_cls == CLS_MISS);
          st_q        <= (start_cls == CLS_MISS) ? ST_DONE : ST_RUN;
        end
        ST_RUN: if (byte_done) begin
          rdata_q[8*idx_q +: 8] <= byte_rd;
          if (idx_q == last_q) st_q <= ST_DONE;
          else                 idx_q <= idx_q + IDX_W'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign io_ack_o       = (st_q == ST_DONE);
  assign io_unclaimed_o = io_ack_o && unclaimed_q;
  assign io_rdata_o     = rdata_q;
  assign cfg_valid_o    = tgt;
  assign cfg_we_o       = we_q;
  assign cfg_dev_o      = cur_port[11:8];
  assign cfg_reg_o      = cur_port[7:0];
  assign cfg_wdata_o    = wdata_q[8*idx_q +: 8];
endmodule

// File: rtl/cfg2_decoder_chk.sv
module cfg2_decoder_chk
  import cfg2_pkg::*;
#(
  parameter logic [NDEV-1:0] DEV_PRESENT = 16'hFFFF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              io_ack_o,
  input logic              io_unclaimed_o,
  input logic [DATA_W-1:0] io_rdata_o,
  input logic              cfg_valid_o,
  input logic              cfg_ready_i,
  input logic              cfg_we_o,
  input logic [7:0]        cfg_bus_o,
  input logic [3:0]        cfg_dev_o,
  input logic [2:0]        cfg_func_o,
  input logic [7:0]        cfg_reg_o,
  input logic [7:0]        cfg_wdata_o
);
  a_r9_hold_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o && !cfg_ready_i |=> cfg_valid_o &&
      $stable({cfg_we_o, cfg_bus_o, cfg_dev_o, cfg_func_o, cfg_reg_o, cfg_wdata_o}));

  a_r9_quiet_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_ack_o |-> !cfg_valid_o);

  a_r7_only_present: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |-> DEV_PRESENT[cfg_dev_o]);

  a_r10_unclaimed_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_unclaimed_o |-> io_ack_o && (io_rdata_o == '1));

  a_r11_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_ack_o |=> !io_ack_o);
endmodule

bind cfg2_decoder cfg2_decoder_chk #(.DEV_PRESENT(DEV_PRESENT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .io_ack_o(io_ack_o), .io_unclaimed_o(io_unclaimed_o),
  .io_rdata_o(io_rdata_o), .cfg_valid_o(cfg_valid_o), .cfg_ready_i(cfg_ready_i),
  .cfg_we_o(cfg_we_o), .cfg_bus_o(cfg_bus_o), .cfg_dev_o(cfg_dev_o),
  .cfg_func_o(cfg_func_o), .cfg_reg_o(cfg_reg_o), .cfg_wdata_o(cfg_wdata_o)
);

// File: tb/sim_cfg2_decoder.sv
`timescale 1ns/1ps
module sim_cfg2_decoder;
  localparam logic [15:0] PRESENT = 16'h5A35;

  logic clk_i = 1'b0, rst_ni = 1'b0, dev0_en_i = 1'b0;
  logic io_req_i = 1'b0, io_we_i = 1'b0;
  logic [1:0] io_size_i = '0;
  logic [15:0] io_addr_i = '0;
  logic [31:0] io_wdata_i = '0;
  logic io_ack_o, io_unclaimed_o, cfg_valid_o, cfg_we_o;
  logic [31:0] io_rdata_o;
  logic cfg_ready_i = 1'b1;
  logic [7:0] cfg_bus_o, cfg_reg_o, cfg_wdata_o, cfg_rdata_i;
  logic [3:0] cfg_dev_o;
  logic [2:0] cfg_func_o;

  int checks = 0, fails = 0, cyc = 0;
  bit stall = 1'b0;

  always #2.5 clk_i = ~clk_i;

  cfg2_decoder #(.DEV_PRESENT(PRESENT)) u0 (.*);

  function automatic logic [7:0] tgt_data(logic [7:0] b, logic [3:0] d, logic [2:0] f, logic [7:0] r);
    return r ^ {d, f, 1'b0} ^ {b[4:0], b[7:5]};
  endfunction
  assign cfg_rdata_i = tgt_data(cfg_bus_o, cfg_dev_o, cfg_func_o, cfg_reg_o);

  always @(negedge clk_i) cfg_ready_i <= stall ? 1'($urandom % 2) : 1'b1;

  // downstream request log
  logic [31:0] caplog [256];
  int cap_total = 0;
  always @(posedge clk_i)
    if (rst_ni && cfg_valid_o && cfg_ready_i) begin
      caplog[cap_total % 256] <= {cfg_we_o, cfg_bus_o, cfg_dev_o, cfg_func_o, cfg_reg_o,
                                  cfg_we_o ? cfg_wdata_o : 8'h00};
      cap_total <= cap_total + 1;
    end

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // reference model
  logic [3:0] m_key; logic [2:0] m_func; logic [7:0] m_bus, m_mech;
  bit m_open, m_forced, m_dev0;
  logic [31:0] exp_log [8];
  int nexp;

  function automatic int m_cls(logic [15:0] p);
    if (p == 16'hCF8) return 1;
    if (p == 16'hCFA) return 2;
    if (p == 16'hCFB) return 3;
    if (p[15:12] == 4'hC) begin
      if (p[11:8] == 4'h0) return (m_open || m_dev0) ? 4 : 0;
      return m_open ? 4 : 0;
    end
    return 0;
  endfunction

  task automatic m_byte(input logic we, input logic [15:0] p, input logic [7:0] wd, output logic [7:0] rd);
    int c = m_cls(p);
    rd = 8'hFF;
    case (c)
      1: begin
        rd = {m_key, m_func, 1'b0};
        if (we) begin m_key = wd[7:4]; m_func = wd[3:1]; m_forced = 0; m_open = (wd[7:4] != 0); end
      end
      2: begin
        rd = m_bus;
        if (we) begin m_bus = wd; m_forced = 1; m_open = 1; end
      end
      3: begin
        rd = m_mech;
        if (we) begin
          if (!m_mech[0] && wd[0]) m_open = 0;
          else if (m_mech[0] && !wd[0]) m_open = (m_key != 0) || m_forced;
          m_mech = wd;
        end
      end
      4: if (PRESENT[p[11:8]]) begin
        exp_log[nexp] = {we, m_bus, p[11:8], m_func, p[7:0], we ? wd : 8'h00};
        nexp++;
        rd = tgt_data(m_bus, p[11:8], m_func, p[7:0]);
      end
      default: ;
    endcase
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input bit d0);
    rst_ni = 1'b0; dev0_en_i = d0;
    m_key = 0; m_func = 0; m_bus = 0; m_mech = 0; m_open = 0; m_forced = 0; m_dev0 = d0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic access(input logic we, input logic [15:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input string req);
    int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    bit exp_unc = (m_cls(a) == 0);
    logic [31:0] exp_rd = '1;
    logic [7:0] b;
    int start, lat = 0, exp_lat;
    bit got = 0;
    nexp = 0;
    if (!exp_unc)
      for (int i = 0; i < n; i++) begin
        m_byte(we, 16'(a + 16'(i)), wd[8*i +: 8], b);
        exp_rd[8*i +: 8] = b;
      end
    exp_lat = exp_unc ? 1 : n + 1;
    start = cap_total;
    io_req_i = 1'b1; io_we_i = we; io_addr_i = a; io_size_i = sz; io_wdata_i = wd;
    while (!got && lat < 200) begin
      @(negedge clk_i);
      io_req_i = 1'b0;
      lat++;
      if (io_ack_o) got = 1;
    end
    chk(got, "R9", 32'(got), 32'd1);
    if (got) begin
      chk(io_unclaimed_o == exp_unc, "R10", 32'(io_unclaimed_o), 32'(exp_unc));
      if (!we) chk(io_rdata_o == exp_rd, req, io_rdata_o, exp_rd);
      if (!stall) chk(lat == exp_lat, "R11", 32'(lat), 32'(exp_lat));
    end
    chk(cap_total - start == nexp, req, 32'(cap_total - start), 32'(nexp));
    if (cap_total - start == nexp)
      for (int i = 0; i < nexp; i++)
        chk(caplog[(start + i) % 256] == exp_log[i], req, caplog[(start + i) % 256], exp_log[i]);
    @(negedge clk_i);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset(1'b0);
    // R1 reset state
    access(0, 16'hCF8, 0, 0, "R1");
    access(0, 16'hCFA, 0, 0, "R1");
    access(0, 16'hCFB, 0, 0, "R1");
    access(0, 16'hC100, 0, 0, "R1");
    access(0, 16'hC000, 1, 0, "R6");
    access(0, 16'hBFFF, 1, 0, "R10");
    // R2 key/function
    access(1, 16'hCF8, 0, 32'h35, "R2");
    access(0, 16'hCF8, 0, 0, "R2");
    // R5 window decode
    access(0, 16'hC210, 0, 0, "R5");
    access(1, 16'hC4A7, 0, 32'h5C, "R5");
    access(0, 16'hC010, 0, 0, "R6");
    // R7 absent device / miss
    access(0, 16'hC104, 0, 0, "R7");
    access(1, 16'hC104, 1, 32'hBEEF, "R7");
    access(0, 16'hC3FF, 1, 0, "R7");
    // R8 multi-byte, crossing device boundary
    access(1, 16'hC4FD, 2, 32'hA1B2C3D4, "R8");
    access(0, 16'hC4FD, 2, 0, "R8");
    access(0, 16'hCF8, 2, 0, "R8");
    // R2 close
    access(1, 16'hCF8, 0, 32'h04, "R2");
    access(0, 16'hC200, 0, 0, "R2");
    // R3 bus forces open
    access(1, 16'hCFA, 0, 32'h27, "R3");
    access(0, 16'hCFA, 0, 0, "R3");
    access(0, 16'hC213, 0, 0, "R3");
    // R4 mechanism select
    access(1, 16'hCFB, 0, 32'h01, "R4");
    access(0, 16'hCFB, 0, 0, "R4");
    access(0, 16'hC200, 0, 0, "R4");
    access(1, 16'hCFB, 0, 32'h00, "R4");
    access(0, 16'hC200, 0, 0, "R4");
    access(1, 16'hCF8, 0, 32'h00, "R4");
    access(1, 16'hCFB, 0, 32'h81, "R4");
    access(1, 16'hCFB, 0, 32'h80, "R4");
    access(0, 16'hC200, 0, 0, "R4");
    // R8 dword through all control ports, ordered
    access(1, 16'hCF8, 2, 32'h00_11_33_E6, "R8");
    access(0, 16'hCF8, 2, 0, "R8");
    access(1, 16'hCFB, 0, 32'h00, "R8");
    access(0, 16'hCF8, 2, 0, "R8");
    // R9 with stalls
    stall = 1'b1;
    access(1, 16'hC520, 2, 32'h0BADF00D, "R9");
    access(0, 16'hC520, 2, 0, "R9");
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [15:0] a;
      int r = $urandom % 8;
      stall = ($urandom % 2) == 1;
      case (r)
        5: a = 16'(16'hCF8 + 16'($urandom % 4));
        6: a = 16'($urandom);
        7: a = {8'hC0, 8'($urandom)};
        default: a = {4'hC, 12'($urandom)};
      endcase
      access(1'($urandom % 2), a, 2'($urandom % 3), $urandom, "R8");
    end
    // R6 device-zero strap
    stall = 1'b0;
    do_reset(1'b1);
    access(0, 16'hC010, 0, 0, "R6");
    access(1, 16'hC0FE, 1, 32'h1234, "R6");
    access(0, 16'hC110, 0, 0, "R6");
    access(1, 16'hCF8, 0, 32'hE2, "R6");
    access(0, 16'hC110, 0, 0, "R6");
    access(1, 16'hCF8, 0, 32'h00, "R6");
    access(0, 16'hC0FF, 2, 0, "R6");
    for (int k = 0; k < 200; k++) begin
      stall = ($urandom % 2) == 1;
      access(1'($urandom % 2), ($urandom % 4 == 0) ? 16'(16'hCF8 + 16'($urandom % 4)) : {4'hC, 12'($urandom)},
             2'($urandom % 3), $urandom, "R6");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule